// File: doc/BRIEF.md
# Execute Group Redirect Generator

This block sits at the execute stage of an out-of-order core. Each cycle it takes one issued group of up to `NSLOT` instruction slots. It walks the slots in order and decides which ones are processed. It counts how many functional units the processed slots use. Each memory slot is steered to a load or a store execute strobe. From the whole group the block produces at most one fetch redirect.

A redirect comes from a branch that was mispredicted or from a memory-order violation that the load/store queue reports against a slot. The first slot that has a cause wins. Within one slot, the branch mispredict outranks the violation.

A squashed slot still passes to commit as executed, but it uses no functional unit and cannot cause a redirect. All outputs are registered. Two running counters record mispredicts that had been predicted taken and memory-order violations. Computing results and accessing memory are done elsewhere.

Top module: `exec_redirect_gen`

## Requirements
- R1: Slots are taken in ascending index order. A slot is processed (`exec_o` bit set) only if it and every lower slot are valid and processed. The first invalid slot ends the group.
- R2: A processed slot that is not squashed uses one functional unit (`fu_o` bit set). No slot is processed once `EXEC_W` units have been used in the group, even a squashed one.
- R3: A processed squashed slot has `exec_o` set and `fu_o` clear. It raises no load or store strobe and causes no redirect.
- R4: A slot with its `fu_o` bit set raises `ld_exec_o` when its is-load input is 1. It raises `st_exec_o` when its is-store input is 1 and its is-load input is 0. Only slots with `fu_o` set can raise either strobe.
- R5: At most one redirect is reported per group. It comes from the lowest-index slot that uses a functional unit and has either a mispredict or a violation flag. `redir_squash_o` is 1 exactly when a redirect is reported.
- R6: When the winning slot has both a mispredict and a violation, the redirect is a branch redirect (`redir_brmis_o`=1, `iq_viol_o`=0).
- R7: A branch redirect carries the slot's sequence number, PC and next PC. `redir_taken_o` is 1 when the next PC differs from PC+4.
- R8: A memory redirect carries the slot's sequence number and next PC, and sets `iq_viol_o`. `redir_mispc_o`, `redir_brmis_o` and `redir_taken_o` are 0.
- R9: Every output is registered and reflects the group presented one clock earlier. During reset all outputs are 0. With no redirect, all redirect fields are 0.
- R10: `taken_miss_cnt_o` increments once for each branch redirect whose slot was predicted taken. `viol_cnt_o` increments once for each memory redirect. Both wrap at 2^`CNT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| valid_i | input | NSLOT | slot holds an instruction |
| squashed_i | input | NSLOT | slot instruction is squashed |
| is_load_i | input | NSLOT | slot is a load |
| is_store_i | input | NSLOT | slot is a store |
| mispred_i | input | NSLOT | slot branch was mispredicted |
| pred_taken_i | input | NSLOT | slot branch was predicted taken |
| viol_i | input | NSLOT | load/store queue reports an order violation for this slot |
| pc_i | input | NSLOT x PC_W | slot PC |
| npc_i | input | NSLOT x PC_W | slot resolved next PC |
| seq_i | input | NSLOT x SEQ_W | slot sequence number |
| exec_o | output | NSLOT | slot processed and forwarded to commit |
| fu_o | output | NSLOT | slot used a functional unit |
| ld_exec_o | output | NSLOT | load execute strobe |
| st_exec_o | output | NSLOT | store execute strobe |
| redir_squash_o | output | 1 | redirect present |
| redir_seq_o | output | SEQ_W | sequence number of the redirecting slot |
| redir_mispc_o | output | PC_W | PC of the mispredicted branch |
| redir_npc_o | output | PC_W | next PC to fetch from |
| redir_brmis_o | output | 1 | redirect is a branch mispredict |
| redir_taken_o | output | 1 | corrected branch direction |
| iq_viol_o | output | 1 | memory-order violation notice to the issue queue |
| taken_miss_cnt_o | output | CNT_W | count of predicted-taken mispredicts |
| viol_cnt_o | output | CNT_W | count of memory-order violations |

## Verification
The hardest case to reach is a group where the execute-width limit cuts the walk short while squashed slots and redirect causes sit both before and after the cut. In that case the redirect must come from a slot ahead of the cut, and a cause behind the cut must be ignored. Directed groups build this case on purpose: full-width groups with a trailing mispredict, leading squashed slots that carry causes, and one slot that has both causes. A long run of biased random groups follows, which keeps most slots valid so the limit is hit often. A behavioural model in the bench checks every output on every cycle.

// File: rtl/erg_pkg.sv
package erg_pkg;
  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_BRANCH = 2'd1,
    RD_MEMORY = 2'd2
  } redir_kind_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/erg_slot_scan.sv
module erg_slot_scan #(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned EXEC_W = 3
) (
  input  logic [NSLOT-1:0] valid_i,
  input  logic [NSLOT-1:0] squashed_i,
  output logic [NSLOT-1:0] proc_o,
  output logic [NSLOT-1:0] fu_o
);
  localparam int unsigned CW = $clog2(NSLOT + 1) + 1;

  logic [CW-1:0] cnt   [NSLOT+1];
  logic          alive [NSLOT+1];

  assign cnt[0]   = '0;
  assign alive[0] = 1'b1;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign proc_o[g]    = alive[g] & valid_i[g] & (cnt[g] < CW'(EXEC_W));
    assign fu_o[g]      = proc_o[g] & ~squashed_i[g];
    assign alive[g+1]   = proc_o[g];
    assign cnt[g+1]     = cnt[g] + CW'(fu_o[g]);
  end
endmodule

// File: rtl/erg_redirect_pick.sv
module erg_redirect_pick
  import erg_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned SEQ_W = 16
) (
  input  logic [NSLOT-1:0]            fu_i,
  input  logic [NSLOT-1:0]            mispred_i,
  input  logic [NSLOT-1:0]            viol_i,
  input  logic [NSLOT-1:0]            pred_taken_i,
  input  logic [NSLOT-1:0][PC_W-1:0]  pc_i,
  input  logic [NSLOT-1:0][PC_W-1:0]  npc_i,
  input  logic [NSLOT-1:0][SEQ_W-1:0] seq_i,
  output redir_kind_e                 kind_o,
  output logic [SEQ_W-1:0]            seq_o,
  output logic [PC_W-1:0]             mispc_o,
  output logic [PC_W-1:0]             npc_o,
  output logic                        taken_o,
  output logic                        pred_taken_o
);
  logic found;

  always_comb begin
    kind_o       = RD_NONE;
    seq_o        = '0;
    mispc_o      = '0;
    npc_o        = '0;
    taken_o      = 1'b0;
    pred_taken_o = 1'b0;
    found        = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!found && fu_i[i] && (mispred_i[i] || viol_i[i])) begin
        found = 1'b1;
        seq_o = seq_i[i];
        npc_o = npc_i[i];
        // mispredict outranks violation within a slot
        if (mispred_i[i]) begin
          kind_o       = RD_BRANCH;
          mispc_o      = pc_i[i];
          taken_o      = npc_i[i] != (pc_i[i] + PC_W'(INSN_BYTES));
          pred_taken_o = pred_taken_i[i];
        end else begin
          kind_o = RD_MEMORY;
        end
      end
    end
  end
endmodule

// File: rtl/erg_counters.sv
module erg_counters #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             taken_miss_i,
  input  logic             viol_i,
  output logic [CNT_W-1:0] taken_miss_cnt_o,
  output logic [CNT_W-1:0] viol_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_miss_cnt_o <= '0;
      viol_cnt_o       <= '0;
    end else begin
      if (taken_miss_i) taken_miss_cnt_o <= taken_miss_cnt_o + 1'b1;
      if (viol_i)       viol_cnt_o       <= viol_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/exec_redirect_gen.sv
module exec_redirect_gen
  import erg_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned EXEC_W = 3,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned SEQ_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NSLOT-1:0]            valid_i,
  input  logic [NSLOT-1:0]            squashed_i,
  input  logic [NSLOT-1:0]            is_load_i,
  input  logic [NSLOT-1:0]            is_store_i,
  input  logic [NSLOT-1:0]            mispred_i,
  input  logic [NSLOT-1:0]            pred_taken_i,
  input  logic [NSLOT-1:0]            viol_i,
  input  logic [NSLOT-1:0][PC_W-1:0]  pc_i,
  input  logic [NSLOT-1:0][PC_W-1:0]  npc_i,
  input  logic [NSLOT-1:0][SEQ_W-1:0] seq_i,
  output logic [NSLOT-1:0]            exec_o,
  output logic [NSLOT-1:0]            fu_o,
  output logic [NSLOT-1:0]            ld_exec_o,
  output logic [NSLOT-1:0]            st_exec_o,
  output logic                        redir_squash_o,
  output logic [SEQ_W-1:0]            redir_seq_o,
  output logic [PC_W-1:0]             redir_mispc_o,
  output logic [PC_W-1:0]             redir_npc_o,
  output logic                        redir_brmis_o,
  output logic                        redir_taken_o,
  output logic                        iq_viol_o,
  output logic [CNT_W-1:0]            taken_miss_cnt_o,
  output logic [CNT_W-1:0]            viol_cnt_o
);
  logic [NSLOT-1:0] proc_d, fu_d, ld_d, st_d;
  redir_kind_e      kind_d;
  logic [SEQ_W-1:0] seq_d;
  logic [PC_W-1:0]  mispc_d, npc_d;
  logic             taken_d, pred_taken_d;

  erg_slot_scan #(.NSLOT(NSLOT), .EXEC_W(EXEC_W)) i_scan (
    .valid_i   (valid_i),
    .squashed_i(squashed_i),
    .proc_o    (proc_d),
    .fu_o      (fu_d)
  );

  assign ld_d = fu_d & is_load_i;
  assign st_d = fu_d & is_store_i & ~is_load_i;

  erg_redirect_pick #(.NSLOT(NSLOT), .PC_W(PC_W), .SEQ_W(SEQ_W)) i_pick (
    .fu_i        (fu_d),
    .mispred_i   (mispred_i),
    .viol_i      (viol_i),
    .pred_taken_i(pred_taken_i),
    .pc_i        (pc_i),
    .npc_i       (npc_i),
    .seq_i       (seq_i),
    .kind_o      (kind_d),
    .seq_o       (seq_d),
    .mispc_o     (mispc_d),
    .npc_o       (npc_d),
    .taken_o     (taken_d),
    .pred_taken_o(pred_taken_d)
  );

  erg_counters #(.CNT_W(CNT_W)) i_cnt (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .taken_miss_i    ((kind_d == RD_BRANCH) && pred_taken_d),
    .viol_i          (kind_d == RD_MEMORY),
    .taken_miss_cnt_o(taken_miss_cnt_o),
    .viol_cnt_o      (viol_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_o         <= '0;
      fu_o           <= '0;
      ld_exec_o      <= '0;
      st_exec_o      <= '0;
      redir_squash_o <= 1'b0;
      redir_seq_o    <= '0;
      redir_mispc_o  <= '0;
      redir_npc_o    <= '0;
      redir_brmis_o  <= 1'b0;
      redir_taken_o  <= 1'b0;
      iq_viol_o      <= 1'b0;
    end else begin
      exec_o         <= proc_d;
      fu_o           <= fu_d;
      ld_exec_o      <= ld_d;
      st_exec_o      <= st_d;
      redir_squash_o <= kind_d != RD_NONE;
      redir_seq_o    <= seq_d;
      redir_mispc_o  <= mispc_d;
      redir_npc_o    <= npc_d;
      redir_brmis_o  <= kind_d == RD_BRANCH;
      redir_taken_o  <= taken_d;
      iq_viol_o      <= kind_d == RD_MEMORY;
    end
  end
endmodule

// File: rtl/erg_chk.sv
module erg_chk #(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned EXEC_W = 3,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned SEQ_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NSLOT-1:0]            exec_o,
  input logic [NSLOT-1:0]            fu_o,
  input logic [NSLOT-1:0]            ld_exec_o,
  input logic [NSLOT-1:0]            st_exec_o,
  input logic                        redir_squash_o,
  input logic [SEQ_W-1:0]            redir_seq_o,
  input logic [PC_W-1:0]             redir_mispc_o,
  input logic [PC_W-1:0]             redir_npc_o,
  input logic                        redir_brmis_o,
  input logic                        redir_taken_o,
  input logic                        iq_viol_o,
  input logic [CNT_W-1:0]            taken_miss_cnt_o,
  input logic [CNT_W-1:0]            viol_cnt_o
);
  AST_EXEC_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o & (exec_o + NSLOT'(1))) == '0); // R1
  AST_FU_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(fu_o) <= EXEC_W); // R2
  AST_FU_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fu_o & ~exec_o) == '0); // R3
  AST_STROBE_FU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ld_exec_o | st_exec_o) & ~fu_o) == '0); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_exec_o & st_exec_o) == '0); // R4
  AST_ONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_squash_o == (redir_brmis_o ^ iq_viol_o)); // R5
  AST_REDIR_NEEDS_FU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_squash_o |-> (fu_o != '0)); // R5
  AST_MEM_NO_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iq_viol_o |-> (redir_mispc_o == '0 && !redir_taken_o)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redir_squash_o |-> (redir_npc_o == '0 && redir_seq_o == '0)); // R9
  AST_VIOL_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_cnt_o != $past(viol_cnt_o)) |-> iq_viol_o); // R10
  AST_MISS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_miss_cnt_o != $past(taken_miss_cnt_o)) |-> redir_brmis_o); // R10
endmodule

bind exec_redirect_gen erg_chk #(
  .NSLOT(NSLOT), .EXEC_W(EXEC_W), .PC_W(PC_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) i_erg_chk (.*);

// File: tb/test_exec_redirect_gen.sv
`timescale 1ns/1ps
module test_exec_redirect_gen;
  localparam int NSLOT = 4, EXEC_W = 3, PC_W = 32, SEQ_W = 16, CNT_W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NSLOT-1:0] valid_i, squashed_i, is_load_i, is_store_i, mispred_i, pred_taken_i, viol_i;
  logic [NSLOT-1:0][PC_W-1:0]  pc_i, npc_i;
  logic [NSLOT-1:0][SEQ_W-1:0] seq_i;
  logic [NSLOT-1:0] exec_o, fu_o, ld_exec_o, st_exec_o;
  logic redir_squash_o, redir_brmis_o, redir_taken_o, iq_viol_o;
  logic [SEQ_W-1:0] redir_seq_o;
  logic [PC_W-1:0]  redir_mispc_o, redir_npc_o;
  logic [CNT_W-1:0] taken_miss_cnt_o, viol_cnt_o;

  exec_redirect_gen #(.NSLOT(NSLOT), .EXEC_W(EXEC_W), .PC_W(PC_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W))
  i_exec_redirect_gen (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit finished = 0;

  // expected outputs
  logic [NSLOT-1:0] e_exec, e_fu, e_ld, e_st;
  logic e_sq, e_br, e_tk, e_vi;
  logic [SEQ_W-1:0] e_seq;
  logic [PC_W-1:0]  e_mpc, e_npc;
  int   n_miss = 0, n_viol = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model();
    int fu = 0;
    bit stop = 0, got = 0;
    e_exec = '0; e_fu = '0; e_ld = '0; e_st = '0;
    e_sq = 0; e_br = 0; e_tk = 0; e_vi = 0; e_seq = '0; e_mpc = '0; e_npc = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (stop || !valid_i[i] || fu >= EXEC_W) stop = 1;
      else begin
        e_exec[i] = 1;
        if (!squashed_i[i]) begin
          e_fu[i] = 1; fu++;
          if (is_load_i[i]) e_ld[i] = 1;
          else if (is_store_i[i]) e_st[i] = 1;
          if (!got && (mispred_i[i] || viol_i[i])) begin
            got = 1; e_sq = 1; e_seq = seq_i[i]; e_npc = npc_i[i];
            if (mispred_i[i]) begin
              e_br = 1; e_mpc = pc_i[i];
              e_tk = (npc_i[i] != pc_i[i] + 32'd4);
              if (pred_taken_i[i]) n_miss++;
            end else begin
              e_vi = 1; n_viol++;
            end
          end
        end
      end
    end
  endtask

  task automatic compare();
    chk(exec_o == e_exec, "R1 exec", 64'(exec_o), 64'(e_exec));
    chk(fu_o == e_fu, "R2/R3 fu", 64'(fu_o), 64'(e_fu));
    chk(ld_exec_o == e_ld, "R4 ld", 64'(ld_exec_o), 64'(e_ld));
    chk(st_exec_o == e_st, "R4 st", 64'(st_exec_o), 64'(e_st));
    chk(redir_squash_o == e_sq, "R5 squash", 64'(redir_squash_o), 64'(e_sq));
    chk(redir_brmis_o == e_br, "R6 brmis", 64'(redir_brmis_o), 64'(e_br));
    chk(redir_seq_o == e_seq, "R7 seq", 64'(redir_seq_o), 64'(e_seq));
    chk(redir_mispc_o == e_mpc, "R7 mispc", 64'(redir_mispc_o), 64'(e_mpc));
    chk(redir_npc_o == e_npc, "R7 npc", 64'(redir_npc_o), 64'(e_npc));
    chk(redir_taken_o == e_tk, "R7 taken", 64'(redir_taken_o), 64'(e_tk));
    chk(iq_viol_o == e_vi, "R8 iqviol", 64'(iq_viol_o), 64'(e_vi));
    chk(taken_miss_cnt_o == CNT_W'(n_miss), "R10 misscnt", 64'(taken_miss_cnt_o), 64'(CNT_W'(n_miss)));
    chk(viol_cnt_o == CNT_W'(n_viol), "R10 violcnt", 64'(viol_cnt_o), 64'(CNT_W'(n_viol)));
  endtask

  task automatic clear_in();
    valid_i = '0; squashed_i = '0; is_load_i = '0; is_store_i = '0;
    mispred_i = '0; pred_taken_i = '0; viol_i = '0;
    for (int i = 0; i < NSLOT; i++) begin
      pc_i[i]  = PC_W'(32'h1000 + 16 * i);
      npc_i[i] = PC_W'(32'h1000 + 16 * i + 4);
      seq_i[i] = SEQ_W'(100 + i);
    end
  endtask

  task automatic stim(input int n);
    clear_in();
    case (n)
      0: valid_i = 4'b1111;                                  // R2 limit cuts slot 3
      1: begin valid_i = 4'b1101; mispred_i = 4'b0100; end  // R1 hole stops walk
      2: begin valid_i = 4'b1111; squashed_i = 4'b0011;     // R3 squashed, no FU
           mispred_i = 4'b0001; viol_i = 4'b0010; end
      3: begin valid_i = 4'b0111; mispred_i = 4'b0010; pred_taken_i = 4'b0010;
           npc_i[1] = 32'h8000; viol_i = 4'b0100; is_load_i = 4'b0001; is_store_i = 4'b0100; end
      4: begin valid_i = 4'b0011; mispred_i = 4'b0001; viol_i = 4'b0001; end // R6
      5: begin valid_i = 4'b0111; squashed_i = 4'b0001; mispred_i = 4'b0001;
           viol_i = 4'b0100; is_load_i = 4'b0110; is_store_i = 4'b0110; end // R8
      6: begin valid_i = 4'b1111; mispred_i = 4'b1000; viol_i = 4'b1000; end // beyond limit
      7: begin valid_i = 4'b0001; mispred_i = 4'b0001; pred_taken_i = 4'b0001; end // not taken
      8: begin valid_i = 4'b1111; squashed_i = 4'b0100; viol_i = 4'b1000; end
      default: begin
        for (int i = 0; i < NSLOT; i++) begin
          valid_i[i]      = ($urandom % 10) < 9;
          squashed_i[i]   = ($urandom % 4) == 0;
          is_load_i[i]    = ($urandom % 3) == 0;
          is_store_i[i]   = ($urandom % 3) == 0;
          mispred_i[i]    = ($urandom % 6) == 0;
          pred_taken_i[i] = $urandom % 2;
          viol_i[i]       = ($urandom % 6) == 0;
          pc_i[i]         = $urandom & 32'hffff_fffc;
          npc_i[i]        = ($urandom % 2) ? pc_i[i] + 32'd4 : ($urandom & 32'hffff_fffc);
          seq_i[i]        = SEQ_W'($urandom);
        end
      end
    endcase
  endtask

  initial begin
    clear_in();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    model(); // inputs idle -> all-zero expectation
    n_miss = 0; n_viol = 0;
    chk(exec_o == '0 && fu_o == '0 && !redir_squash_o && redir_npc_o == '0 && viol_cnt_o == '0,
        "R9 reset", 64'(exec_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare();
    for (int n = 0; n < 600; n++) begin
      stim(n);
      model();
      @(negedge clk_i);
      compare();
    end
    clear_in(); model();
    @(negedge clk_i);
    compare(); // R9 idle group gives zero redirect fields
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule